// File: doc/BRIEF.md
# Segment Address Extension Unit

This unit widens a 16-bit virtual address into a 22-bit physical address. It holds three 6-bit segment pointers: one for ordinary code, one for interrupt code, and one for DMA data. Each pointer picks one 64-Kbyte window inside a 4-Mbyte space. The kind of access in progress chooses the pointer, and the address bits play no part in that choice. Code, interrupt handlers and DMA transfers can therefore each sit in their own window without reprogramming between them.

The enclosing core reports the access kind through four strobes: normal fetch, interrupt fetch, DMA to program memory and DMA to data memory. The unit decodes those strobes into a named access kind: `KIND_NONE`, `KIND_CODE`, `KIND_IRQ`, `KIND_DMA_PROG` or `KIND_DMA_DATA`. It then places the matching pointer above the 16 untouched low address bits. Translation is combinational from the stored pointers.

A write port loads one pointer per clock edge. A read port returns any pointer on an 8-bit bus. The pointers are not reset, so software must load them before use. If no strobe is active, or more than one is active, the unit flags an error and outputs the virtual address zero-extended.

Top module: `seg_xlate`

## Requirements
- R1: When exactly one access strobe is high, `paddr[15:0]` equals `vaddr`.
- R2: A normal fetch (`acc_code` alone) places the code pointer (index 0) in `paddr[21:16]`.
- R3: An interrupt fetch (`acc_irq` alone) places the interrupt pointer (index 1) in `paddr[21:16]`.
- R4: A DMA access to program memory (`acc_dma_prog` alone) also uses the interrupt pointer (index 1).
- R5: A DMA access to data memory (`acc_dma_data` alone) uses the DMA pointer (index 2).
- R6: `sel_err` is 1 exactly when the number of high strobes is not one; in that case `paddr` = {6'b0, `vaddr`}.
- R7: With `wr_en` high, `wr_data` is loaded into the pointer indexed by `wr_sel` (0 code, 1 interrupt, 2 DMA) at the next rising clock edge and not before. The other pointers keep their values, and `wr_sel` = 3 changes no pointer.
- R8: `rd_data` returns the pointer indexed by `rd_sel` in bits 5:0, with bits 7:6 at zero. `rd_sel` = 3 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (the pointers keep no reset value) |
| vaddr | input | 16 | Virtual address |
| acc_code | input | 1 | Normal program fetch in progress |
| acc_irq | input | 1 | Interrupt routine fetch in progress |
| acc_dma_prog | input | 1 | DMA access to program memory |
| acc_dma_data | input | 1 | DMA access to data memory |
| wr_en | input | 1 | Pointer write enable |
| wr_sel | input | 2 | Pointer index to write |
| wr_data | input | 6 | Pointer write value |
| rd_sel | input | 2 | Pointer index to read |
| rd_data | output | 8 | Read-back value, zero-extended |
| paddr | output | 22 | Physical address |
| sel_err | output | 1 | Strobes not one-hot |

## Verification
The bench builds the unit with its defaults: a 16-bit virtual address, 6-bit pointers and an 8-bit read bus. At these widths every one of the 64 pointer values can be loaded into every pointer. At each load step the bench drives all 16 strobe combinations, so every access kind and every error case is reached for every pointer value. It also probes a write before its clock edge, writes to the unused index 3, and reads from the unused index 3.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int N_PTR    = 3;
    localparam int PTR_CODE = 0;
    localparam int PTR_IRQ  = 1;
    localparam int PTR_DMA  = 2;
    localparam int N_KIND   = 4;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CODE,
        KIND_IRQ,
        KIND_DMA_PROG,
        KIND_DMA_DATA
    } acc_kind_t;
endpackage

// File: rtl/seg_ptr_bank.sv
module seg_ptr_bank
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 6,
    parameter int RD_W  = 8,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [SEG_W-1:0]       wr_data,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [RD_W-1:0]        rd_data,
    output logic [SEG_W-1:0]       ptr_code,
    output logic [SEG_W-1:0]       ptr_irq,
    output logic [SEG_W-1:0]       ptr_dma
);
    logic [SEG_W-1:0] ptr_q [N_PTR];

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == SEL_W'(g))
                ptr_q[g] <= wr_data;
        end

        // R7
        load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g)) |=> (ptr_q[g] == $past(wr_data)));

        // R7
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(ptr_q[g]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_PTR; i++) begin
            if (rd_sel == SEL_W'(i))
                rd_data[SEG_W-1:0] = ptr_q[i];
        end
    end

    assign ptr_code = ptr_q[PTR_CODE];
    assign ptr_irq  = ptr_q[PTR_IRQ];
    assign ptr_dma  = ptr_q[PTR_DMA];
endmodule

// File: rtl/seg_kind_mux.sv
module seg_kind_mux
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 6,
    localparam int PA_W = VA_W + SEG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_KIND-1:0]   strobes,
    input  logic [VA_W-1:0]     vaddr,
    input  logic [SEG_W-1:0]    ptr_code,
    input  logic [SEG_W-1:0]    ptr_irq,
    input  logic [SEG_W-1:0]    ptr_dma,
    output logic [PA_W-1:0]     paddr,
    output logic                sel_err
);
    acc_kind_t        kind;
    logic [SEG_W-1:0] seg;

    always_comb begin
        unique case (strobes)
            4'b0001: kind = KIND_CODE;
            4'b0010: kind = KIND_IRQ;
            4'b0100: kind = KIND_DMA_PROG;
            4'b1000: kind = KIND_DMA_DATA;
            default: kind = KIND_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            KIND_CODE:     seg = ptr_code;
            KIND_IRQ:      seg = ptr_irq;
            KIND_DMA_PROG: seg = ptr_irq;
            KIND_DMA_DATA: seg = ptr_dma;
            default:       seg = '0;
        endcase
        sel_err = (kind == KIND_NONE);
        paddr   = {seg, vaddr};
    end

    // R6
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err == ($countones(strobes) != 1));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (paddr[PA_W-1:VA_W] == '0));

    // R1
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paddr[VA_W-1:0] == vaddr);

    // R2
    code_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == 4'b0001) |-> (paddr[PA_W-1:VA_W] == ptr_code));

    // R4
    dma_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == 4'b0100) |-> (paddr[PA_W-1:VA_W] == ptr_irq));

    // R5
    dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == 4'b1000) |-> (paddr[PA_W-1:VA_W] == ptr_dma));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 6,
    parameter int RD_W  = 8,
    parameter int SEL_W = 2,
    localparam int PA_W = VA_W + SEG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VA_W-1:0]    vaddr,
    input  logic               acc_code,
    input  logic               acc_irq,
    input  logic               acc_dma_prog,
    input  logic               acc_dma_data,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [SEG_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [RD_W-1:0]    rd_data,
    output logic [PA_W-1:0]    paddr,
    output logic               sel_err
);
    logic [SEG_W-1:0]  ptr_code, ptr_irq, ptr_dma;
    logic [N_KIND-1:0] strobes;

    assign strobes = {acc_dma_data, acc_dma_prog, acc_irq, acc_code};

    seg_ptr_bank #(.SEG_W(SEG_W), .RD_W(RD_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .ptr_code (ptr_code),
        .ptr_irq  (ptr_irq),
        .ptr_dma  (ptr_dma)
    );

    seg_kind_mux #(.VA_W(VA_W), .SEG_W(SEG_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobes  (strobes),
        .vaddr    (vaddr),
        .ptr_code (ptr_code),
        .ptr_irq  (ptr_irq),
        .ptr_dma  (ptr_dma),
        .paddr    (paddr),
        .sel_err  (sel_err)
    );

    // R8
    rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:SEG_W] == '0);

    // R3
    irq_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_irq && !acc_code && !acc_dma_prog && !acc_dma_data)
            |-> (paddr[PA_W-1:VA_W] == ptr_irq));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] vaddr = '0;
    logic        acc_code = 0, acc_irq = 0, acc_dma_prog = 0, acc_dma_data = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = '0;
    logic [5:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [21:0] paddr;
    logic        sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [5:0] m_ptr [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr),
        .acc_code(acc_code), .acc_irq(acc_irq),
        .acc_dma_prog(acc_dma_prog), .acc_dma_data(acc_dma_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .paddr(paddr), .sel_err(sel_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ptr(input logic [1:0] idx, input logic [5:0] val);
        @(negedge clk);
        wr_en = 1; wr_sel = idx; wr_data = val;
        @(negedge clk);
        wr_en = 0;
        if (idx != 2'd3) m_ptr[idx] = val;
    endtask

    task automatic check_readback(input string req);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(req, {24'd0, rd_data}, (s == 3) ? 32'd0 : {26'd0, m_ptr[s]});
        end
    endtask

    task automatic sweep_strobes(input logic [15:0] base);
        for (int c = 0; c < 16; c++) begin
            logic [15:0] va;
            logic [5:0]  eseg;
            logic        eerr;
            string       req;
            va = base ^ 16'(c * 4099);
            {acc_dma_data, acc_dma_prog, acc_irq, acc_code} = 4'(c);
            vaddr = va;
            eerr = 0;
            case (c)
                1:       begin eseg = m_ptr[0]; req = "R2"; end
                2:       begin eseg = m_ptr[1]; req = "R3"; end
                4:       begin eseg = m_ptr[1]; req = "R4"; end
                8:       begin eseg = m_ptr[2]; req = "R5"; end
                default: begin eseg = '0; eerr = 1; req = "R6"; end
            endcase
            #1;
            chk(req, {10'd0, paddr}, {10'd0, eseg, va});
            chk(eerr ? "R6" : "R1", {31'd0, sel_err}, {31'd0, eerr});
        end
        {acc_dma_data, acc_dma_prog, acc_irq, acc_code} = 4'b0000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        vaddr = 16'hBEEF;
        #1;
        chk("R6", {31'd0, sel_err}, 32'd1);
        chk("R6", {10'd0, paddr}, 32'h0000BEEF);

        write_ptr(2'd0, 6'h00);
        write_ptr(2'd1, 6'h00);
        write_ptr(2'd2, 6'h00);

        for (int v = 0; v < 64; v++) begin
            write_ptr(2'd0, 6'(v));
            write_ptr(2'd1, 6'(v + 21));
            write_ptr(2'd2, 6'(v * 5 + 3));
            check_readback("R8");
            sweep_strobes(16'(v * 1031));
        end

        // R7: writes to index 3 change nothing
        write_ptr(2'd3, 6'h2A);
        check_readback("R7");

        // R7: a write is not visible before its clock edge
        @(negedge clk);
        rd_sel = 2'd1;
        wr_en = 1; wr_sel = 2'd1; wr_data = ~m_ptr[1];
        #1;
        chk("R7", {24'd0, rd_data}, {26'd0, m_ptr[1]});
        @(negedge clk);
        wr_en = 0;
        m_ptr[1] = ~m_ptr[1];
        #1;
        chk("R7", {24'd0, rd_data}, {26'd0, m_ptr[1]});
        check_readback("R7");
        sweep_strobes(16'h5A5A);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule